// File: doc/BRIEF.md
# DAC Data Buffer Controller

This block holds a small table of 12-bit conversion words and chooses which one drives a digital-to-analog converter. A single pointer byte carries a read pointer and a second nibble. In cyclic mode the second nibble is an upper bound: each qualified trigger steps the read pointer through the table and wraps it back to entry zero. In queue mode the same nibble serves as a write pointer. Software pushes words through the data addresses, and triggers pop them.

Software reaches the table and the pointer byte through a simple register port. Writes take effect at the clock edge. Reads are combinational. The converter enable and the buffer enable select what drives the output: zero, word 0, or the entry under the read pointer. The output code is registered. It shows the state that results from the cycle's trigger, write or enable change one clock later.

Top module: `dacbuf_ctrl`

## Requirements
- R1: After reset the pointer byte reads 0x0F (read pointer 0, upper nibble field 15), every table entry reads 0 and the output code is 0.
- R2: Register addresses 0..15 are the table entries (12 bits each). Address 16 is the pointer byte: read pointer in bits 7:4, limit/write pointer in bits 3:0. Addresses 17..31 read 0 and ignore writes. Reads are combinational.
- R3: While the converter enable is low the output code is 0.
- R4: With the converter enabled and the buffer disabled the output code is table word 0, and triggers leave the pointers unchanged.
- R5: With both enables high the output code is the table entry selected by the read pointer.
- R6: In cyclic mode, a trigger with both enables high advances the read pointer by one. If the read pointer is at or above the limit, it goes to 0 instead.
- R7: The output code is registered. It changes on the clock edge that samples the trigger, write or enable change, and not before.
- R8: When the queue-mode input rises, the low nibble is loaded with the read pointer and the queue is empty. Data writes and triggers in that entry cycle are dropped.
- R9: In queue mode, a write to any table address (0..15) stores the word at the write pointer and advances it modulo 16. Once 16 words are held the queue is full, and further writes are dropped.
- R10: In queue mode, a qualified trigger advances the read pointer modulo 16 only when the queue is not empty.
- R11: A pointer-byte write in queue mode loads both pointers and leaves the queue empty when they are equal. A pointer-byte write takes priority over a trigger or mode entry in the same cycle.
- R12: In cyclic mode a write to a table address stores the word in that entry, and a pointer-byte write sets the read pointer and the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dac_en | input | 1 | Converter enable |
| buf_en | input | 1 | Buffer enable |
| fifo_mode | input | 1 | Queue-mode select (1) versus cyclic mode (0) |
| trig | input | 1 | Hardware or software trigger pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data (combinational) |
| dac_code | output | 12 | Registered output code |

## Verification
The cyclic stepping is swept with the full-range limit over more than two laps and with a short limit. This shows the wrap at the limit apart from natural rollover at 15. A pointer written above the limit confirms the at-or-above wrap rule. Queue mode is filled from an offset start until the write pointer wraps, pushed once more while full, and drained until empty with an extra trigger. Each output word is compared to its arithmetically generated value. A flush with equal pointers, followed by one push that must be accepted, tells an emptied queue apart from a full one.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_WORD0 = 2'd1,
        SRC_PTR   = 2'd2
    } code_src_e;
endpackage

// File: rtl/dacbuf_ptr.sv
module dacbuf_ptr #(
    parameter int PTR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode,
    input  logic               ctrl_we,
    input  logic [2*PTR_W-1:0] ctrl_wdata,
    input  logic               pop_req,
    input  logic               push_req,
    output logic [PTR_W-1:0]   rp_q,
    output logic [PTR_W-1:0]   lo_q,
    output logic [PTR_W-1:0]   rp_d,
    output logic               fifo_act,
    output logic               mode_entry,
    output logic               fifo_full,
    output logic               fifo_empty,
    output logic               push_ok
);
    localparam logic [PTR_W:0]   EXT_ONE = (PTR_W+1)'(1);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    typedef struct packed {
        logic             mode;
        logic             rwrap;
        logic             lwrap;
        logic [PTR_W-1:0] rp;
        logic [PTR_W-1:0] lo;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.mode  = fifo_mode;
        fifo_act   = fifo_mode & st_q.mode;
        mode_entry = fifo_mode & ~st_q.mode;
        fifo_empty = (st_q.rp == st_q.lo) && (st_q.rwrap == st_q.lwrap);
        fifo_full  = (st_q.rp == st_q.lo) && (st_q.rwrap != st_q.lwrap);
        push_ok    = 1'b0;
        if (ctrl_we) begin
            st_d.rp    = ctrl_wdata[2*PTR_W-1:PTR_W];
            st_d.lo    = ctrl_wdata[PTR_W-1:0];
            st_d.rwrap = 1'b0;
            st_d.lwrap = 1'b0;
        end else if (mode_entry) begin
            st_d.lo    = st_q.rp;
            st_d.rwrap = 1'b0;
            st_d.lwrap = 1'b0;
        end else if (fifo_act) begin
            if (push_req && !fifo_full) begin
                push_ok                = 1'b1;
                {st_d.lwrap, st_d.lo}  = {st_q.lwrap, st_q.lo} + EXT_ONE;
            end
            if (pop_req && !fifo_empty) begin
                {st_d.rwrap, st_d.rp}  = {st_q.rwrap, st_q.rp} + EXT_ONE;
            end
        end else if (pop_req) begin
            st_d.rp = (st_q.rp >= st_q.lo) ? '0 : st_q.rp + PTR_ONE;
        end
        rp_d = st_d.rp;
        rp_q = st_q.rp;
        lo_q = st_q.lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.lo    <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dacbuf_mem.sv
module dacbuf_mem #(
    parameter int DATA_W = 12,
    parameter int PTR_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [PTR_W-1:0]                 waddr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [(1<<PTR_W)-1:0][DATA_W-1:0] mem_q,
    output logic [(1<<PTR_W)-1:0][DATA_W-1:0] mem_d
);
    localparam int DEPTH = 1 << PTR_W;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_comb begin
            mem_d[i] = mem_q[i];
            if (we && (waddr == PTR_W'(i))) begin
                mem_d[i] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end
endmodule

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl #(
    parameter int DATA_W = 12,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dac_en,
    input  logic              buf_en,
    input  logic              fifo_mode,
    input  logic              trig,
    input  logic              reg_wr,
    input  logic [PTR_W:0]    reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] dac_code
);
    import dacbuf_pkg::*;

    localparam int DEPTH = 1 << PTR_W;
    localparam logic [PTR_W:0] CTRL_ADDR = (PTR_W+1)'(DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] code;
    } out_st_t;

    out_st_t out_d, out_q;

    logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;
    logic [PTR_W-1:0] rp_q, lo_q, rp_d;
    logic fifo_act, mode_entry, fifo_full, fifo_empty, push_ok;
    logic data_we, ctrl_we, pop_req, mem_we;
    logic [PTR_W-1:0] mem_waddr;
    code_src_e src;

    assign data_we   = reg_wr && (reg_addr[PTR_W] == 1'b0);
    assign ctrl_we   = reg_wr && (reg_addr == CTRL_ADDR);
    assign pop_req   = trig && dac_en && buf_en;
    assign mem_we    = fifo_act ? push_ok : (data_we && !mode_entry);
    assign mem_waddr = fifo_act ? lo_q : reg_addr[PTR_W-1:0];

    dacbuf_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (reg_wdata[2*PTR_W-1:0]),
        .pop_req    (pop_req),
        .push_req   (data_we),
        .rp_q       (rp_q),
        .lo_q       (lo_q),
        .rp_d       (rp_d),
        .fifo_act   (fifo_act),
        .mode_entry (mode_entry),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .push_ok    (push_ok)
    );

    dacbuf_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (reg_wdata),
        .mem_q (mem_q),
        .mem_d (mem_d)
    );

    always_comb begin
        if (!dac_en)      src = SRC_OFF;
        else if (!buf_en) src = SRC_WORD0;
        else              src = SRC_PTR;
        out_d = out_q;
        case (src)
            SRC_WORD0: out_d.code = mem_d[0];
            SRC_PTR:   out_d.code = mem_d[rp_d];
            default:   out_d.code = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[PTR_W] == 1'b0) begin
            reg_rdata = mem_q[reg_addr[PTR_W-1:0]];
        end else if (reg_addr == CTRL_ADDR) begin
            reg_rdata = DATA_W'({rp_q, lo_q});
        end
    end

    assign dac_code = out_q.code;
endmodule

// File: rtl/dacbuf_chk.sv
module dacbuf_chk #(
    parameter int DATA_W = 12,
    parameter int PTR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dac_en,
    input logic              ctrl_we,
    input logic              pop_req,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] dac_code,
    input logic [PTR_W-1:0]  rp_q,
    input logic [PTR_W-1:0]  lo_q,
    input logic              fifo_act,
    input logic              mode_entry,
    input logic              fifo_full,
    input logic              fifo_empty
);
    AST_CODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_en |=> dac_code == '0); // R3
    AST_CYCLIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_act && !mode_entry && !ctrl_we && pop_req && rp_q >= lo_q) |=> rp_q == '0); // R6
    AST_ENTRY_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_entry && !ctrl_we) |=> (lo_q == $past(rp_q)) && fifo_empty); // R8
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_act && fifo_full && !ctrl_we) |=> lo_q == $past(lo_q)); // R9
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_act && fifo_empty && !ctrl_we) |=> rp_q == $past(rp_q)); // R10
    AST_CTRL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> rp_q == $past(reg_wdata[2*PTR_W-1:PTR_W])); // R11
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty)); // R9
endmodule

bind dacbuf_ctrl dacbuf_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dac_en     (dac_en),
    .ctrl_we    (ctrl_we),
    .pop_req    (pop_req),
    .reg_wdata  (reg_wdata),
    .dac_code   (dac_code),
    .rp_q       (rp_q),
    .lo_q       (lo_q),
    .fifo_act   (fifo_act),
    .mode_entry (mode_entry),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
);

// File: tb/sim_dacbuf_ctrl.sv
module sim_dacbuf_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 12;
    localparam int PTR_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dac_en = 1'b0, buf_en = 1'b0, fifo_mode = 1'b0, trig = 1'b0, reg_wr = 1'b0;
    logic [PTR_W:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata, dac_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacbuf_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .dac_en(dac_en), .buf_en(buf_en),
        .fifo_mode(fifo_mode), .trig(trig), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dac_code(dac_code)
    );

    function automatic int fw(int i);
        return (i * 397 + 5) % 4096;
    endfunction

    function automatic int gw(int k);
        return (k * 733 + 1000) % 4096;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(int a, output int v);
        reg_addr = a[PTR_W:0];
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a[PTR_W:0]; reg_wdata = d[DATA_W-1:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int v;
        int rp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(16, v); chk("R1 ctrl", v, 'h0F);
        chk("R1 code", int'(dac_code), 0);
        for (int i = 0; i < 16; i++) begin
            rd(i, v); chk("R1 entry", v, 0);
        end
        // R12 / R2 cyclic data writes and readback
        for (int i = 0; i < 16; i++) wr(i, fw(i));
        for (int i = 0; i < 16; i++) begin
            rd(i, v); chk("R12 entry", v, fw(i));
        end
        wr(20, 'h777);
        rd(20, v); chk("R2 unmapped", v, 0);
        rd(16, v); chk("R2 ctrl untouched", v, 'h0F);
        // R3 converter off
        chk("R3 off", int'(dac_code), 0);
        // R7 / R4 enable timing
        @(negedge clk);
        dac_en = 1'b1;
        #1; chk("R7 before edge", int'(dac_code), 0);
        @(negedge clk);
        chk("R4 word0", int'(dac_code), fw(0));
        pulse();
        rd(16, v); chk("R4 trig ignored", v, 'h0F);
        // R5 / R6 full-range sweep
        @(negedge clk);
        buf_en = 1'b1;
        @(negedge clk);
        rp = 0;
        for (int n = 0; n < 40; n++) begin
            pulse();
            rp = (rp >= 15) ? 0 : rp + 1;
            chk("R5 code", int'(dac_code), fw(rp));
            rd(16, v); chk("R6 ptr", v, rp * 16 + 15);
        end
        // R12 / R6 short limit
        wr(16, 'h05);
        rd(16, v); chk("R12 ctrl", v, 'h05);
        chk("R5 code after ctrl", int'(dac_code), fw(0));
        rp = 0;
        for (int n = 0; n < 20; n++) begin
            pulse();
            rp = (rp >= 5) ? 0 : rp + 1;
            chk("R6 short code", int'(dac_code), fw(rp));
        end
        wr(16, 'h95);
        pulse();
        rd(16, v); chk("R6 above limit", v, 'h05);
        // R11 priority of pointer write over trigger
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd16; reg_wdata = 12'h042; trig = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; trig = 1'b0;
        rd(16, v); chk("R11 priority", v, 'h42);
        chk("R5 code at 4", int'(dac_code), fw(4));
        // R8 queue entry
        wr(16, 'h37);
        @(negedge clk);
        fifo_mode = 1'b1;
        @(negedge clk);
        rd(16, v); chk("R8 snap", v, 'h33);
        pulse();
        rd(16, v); chk("R10 empty pop", v, 'h33);
        // R9 fill
        for (int k = 0; k < 16; k++) begin
            wr(0, gw(k));
            rd(16, v); chk("R9 wptr", v, 'h30 + ((4 + k) % 16));
        end
        wr(5, 'hABC);
        rd(3, v); chk("R9 full drop", v, gw(0));
        rd(16, v); chk("R9 full ptr", v, 'h33);
        chk("R5 queue head", int'(dac_code), gw(0));
        // R10 drain
        for (int k = 0; k < 16; k++) begin
            pulse();
            rd(16, v); chk("R10 rptr", v, ((4 + k) % 16) * 16 + 3);
            if (k < 15) chk("R10 code", int'(dac_code), gw(k + 1));
        end
        pulse();
        rd(16, v); chk("R10 empty hold", v, 'h33);
        // R11 flush
        wr(0, 'h111);
        rd(16, v); chk("R9 push", v, 'h34);
        wr(16, 'hAA);
        pulse();
        rd(16, v); chk("R11 flushed", v, 'hAA);
        wr(0, 'h222);
        rd(10, v); chk("R11 push after flush", v, 'h222);
        rd(16, v); chk("R11 wptr after flush", v, 'hAB);
        finish_run();
    end
endmodule